// File: doc/BRIEF.md
# Link-Bit Issue Group Splitter

This block sits between instruction fetch and issue in a wide in-order core. Each transfer from fetch carries a fixed-size packet of eight 32-bit instruction words. A single flag inside every word says whether the word that follows it issues in the same cycle. The splitter stores the fetched packet. It then presents one issue group per cycle to the issue stage, and it holds fetch off until the last group of the stored packet has been taken.

Each issue group is shown as a slot mask plus all eight instruction words, with every word kept in the slot it was fetched into. Issue logic further down can then route instructions by slot without shifting them. The words are not decoded here. Both edges use a valid/ready handshake. A group that is offered but not accepted stays on the output unchanged. When the final group of one packet is accepted, the next fetch packet can be loaded in the same cycle, so issue does not lose a bubble between packets.

Top module: `execPacketSplitter`

## Requirements
- R1: After reset, `issueValid` is 0 and `fetchReady` is 1.
- R2: A fetch packet is accepted on a clock edge where `fetchValid` and `fetchReady` are both 1. In the next cycle `issueValid` is 1 and the output shows the packet's first issue group, which always begins at slot 0.
- R3: Bit 0 of each instruction word is the link flag. A 1 in slot i's word places slot i+1 in the same issue group as slot i. A 0 ends the group at slot i.
- R4: `issueMask` marks one contiguous run of slots. Each slot inside the mask carries its fetched word unchanged at its own position (slot i on bits [32*i+31:32*i] of `issueWords`). Slots outside the mask read as zero.
- R5: The groups of a packet come out in ascending slot order, one group per accepted issue cycle. Every slot appears in exactly one group.
- R6: The link flag of slot 7 has no effect. An issue group never spans two fetch packets, so the next packet's first group starts again at slot 0.
- R7: While issue groups of the stored packet remain, `fetchReady` is 0. The one exception is a cycle where the final group is being accepted (`issueReady` = 1).
- R8: While `issueValid` is 1 and `issueReady` is 0, the next cycle shows `issueValid`, `issueMask` and `issueWords` unchanged.
- R9: If the final group is accepted in the same cycle that a new fetch packet is accepted, the next cycle shows the new packet's first group with `issueValid` = 1.
- R10: A packet whose words all have the link flag set issues as a single group with mask 0xFF. A packet whose words all have the flag clear issues as eight single-slot groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchValid | input | 1 | A fetch packet is offered |
| fetchReady | output | 1 | The splitter can take a fetch packet this cycle |
| fetchWords | input | 256 | Eight instruction words; slot i on bits [32*i+31:32*i] |
| issueValid | output | 1 | An issue group is offered |
| issueReady | input | 1 | The issue stage accepts the offered group |
| issueMask | output | 8 | Slots that belong to the offered group |
| issueWords | output | 256 | Instruction words in their fetched slots; slots outside the mask are zero |

## Verification
Two events can fall in the same cycle: the issue stage accepts the final group of the stored packet, and a new fetch packet is loaded. The bench keeps `fetchValid` high across long runs of random packets while `issueReady` is high most of the time, so this overlap happens over and over. The bench also injects stalls in the final-group cycle, where `fetchReady` must fall back to 0. In every overlap cycle, the bench's model predicts `fetchReady` from the remaining-slot state it tracks itself. In the next cycle it checks that the new packet's slot-0 group is valid with no gap.

// File: rtl/splitPkg.sv
package splitPkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic load;     // capture a new fetch packet
    logic advance;  // current issue group accepted downstream
  } ctrlStrobe_t;

endpackage

// File: rtl/splitCtrl.sv
module splitCtrl
  import splitPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fetchValid,
  input  logic        issueReady,
  input  logic        busy,
  input  logic        lastGroup,
  output logic        fetchReady,
  output logic        issueValid,
  output ctrlStrobe_t strobe
);

  logic finalTaken;

  always_comb begin
    issueValid     = busy;
    finalTaken     = busy && issueReady && lastGroup;
    fetchReady     = !busy || finalTaken;
    strobe.load    = fetchValid && fetchReady;
    strobe.advance = busy && issueReady;
  end

  // R2: a load always leaves the datapath holding work
  p_load_fills_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> busy);

  // R7: taking the last group without a refill drains the splitter
  p_drain_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && lastGroup && !strobe.load) |=> !busy);

  // R5: a group that is not the last leaves more work behind
  p_more_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !lastGroup) |=> busy);

endmodule

// File: rtl/splitDatapath.sv
module splitDatapath
  import splitPkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int INSTR_W  = 32,
  parameter int LINK_POS = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [SLOTS*INSTR_W-1:0] fetchWords,
  output logic                     busy,
  output logic                     lastGroup,
  output logic [SLOTS-1:0]         groupMask,
  output logic [SLOTS*INSTR_W-1:0] groupWords
);

  localparam int          BUS_W   = SLOTS * INSTR_W;
  localparam logic [SLOTS-1:0] ALL_SLOTS = {SLOTS{1'b1}};

  logic [BUS_W-1:0] wordReg;
  logic [SLOTS-1:0] pendMask;
  logic [SLOTS-1:0] linkVec;

  // Packet and pending-slot registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg  <= '0;
      pendMask <= '0;
    end else if (strobe.load) begin
      wordReg  <= fetchWords;
      pendMask <= ALL_SLOTS;
    end else if (strobe.advance) begin
      pendMask <= pendMask & ~groupMask;
    end
  end

  // Group formation: the group starts at the lowest pending slot and
  // grows while the previous member carries its link flag.
  // Slot SLOTS-1's flag feeds nothing, so it cannot extend a group.
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign linkVec[i] = wordReg[i*INSTR_W + LINK_POS];
    if (i == 0) begin : g_first
      assign groupMask[i] = pendMask[i];
    end else begin : g_rest
      assign groupMask[i] = pendMask[i] &&
                            (!pendMask[i-1] || (groupMask[i-1] && linkVec[i-1]));
    end
    assign groupWords[i*INSTR_W +: INSTR_W] =
      groupMask[i] ? wordReg[i*INSTR_W +: INSTR_W] : '0;
  end

  assign busy      = |pendMask;
  assign lastGroup = ((pendMask & ~groupMask) == '0);

  // R2: every load marks the whole packet as pending
  p_full_after_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (pendMask == ALL_SLOTS));

  // R4: a non-empty group is one contiguous run of slots
  p_contig_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ((groupMask != '0) &&
              ((((groupMask | (groupMask - 1'b1)) + 1'b1) & groupMask) == '0)));

  // R5: groups taken within one packet never overlap
  p_disjoint_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.load) |=> ((groupMask & $past(groupMask)) == '0));

  // R5: pending slots only shrink between loads
  p_pend_shrinks_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ((pendMask & ~$past(pendMask)) == '0));

endmodule

// File: rtl/execPacketSplitter.sv
module execPacketSplitter
  import splitPkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int INSTR_W  = 32,
  parameter int LINK_POS = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fetchValid,
  output logic                     fetchReady,
  input  logic [SLOTS*INSTR_W-1:0] fetchWords,
  output logic                     issueValid,
  input  logic                     issueReady,
  output logic [SLOTS-1:0]         issueMask,
  output logic [SLOTS*INSTR_W-1:0] issueWords
);

  ctrlStrobe_t strobe;
  logic        busy;
  logic        lastGroup;

  splitCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .issueReady (issueReady),
    .busy       (busy),
    .lastGroup  (lastGroup),
    .fetchReady (fetchReady),
    .issueValid (issueValid),
    .strobe     (strobe)
  );

  splitDatapath #(
    .SLOTS    (SLOTS),
    .INSTR_W  (INSTR_W),
    .LINK_POS (LINK_POS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fetchWords (fetchWords),
    .busy       (busy),
    .lastGroup  (lastGroup),
    .groupMask  (issueMask),
    .groupWords (issueWords)
  );

  // R8: a stalled group stays on the output unchanged
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueReady) |=>
      (issueValid && $stable(issueMask) && $stable(issueWords)));

  // R2: the group following a fresh load starts at slot 0
  p_first_slot0_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchReady) |=> (issueValid && issueMask[0]));

endmodule

// File: tb/tb_execPacketSplitter.sv
module tb_execPacketSplitter;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 8;
  localparam int IW         = 32;
  localparam int NPKT       = 300;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  fetchValid = 1'b0;
  logic                  fetchReady;
  logic [SLOTS*IW-1:0]   fetchWords = '0;
  logic                  issueValid;
  logic                  issueReady = 1'b0;
  logic [SLOTS-1:0]      issueMask;
  logic [SLOTS*IW-1:0]   issueWords;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [SLOTS*IW-1:0] pkts [NPKT];

  always #(CLK_PERIOD/2) clk = ~clk;

  execPacketSplitter dut (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchReady(fetchReady), .fetchWords(fetchWords),
    .issueValid(issueValid), .issueReady(issueReady),
    .issueMask(issueMask), .issueWords(issueWords)
  );

  task automatic check(input bit ok, input string req, input logic [SLOTS*IW-1:0] act,
                       input logic [SLOTS*IW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected group: lowest pending slot, extended while link flag (bit 0) is set
  function automatic logic [SLOTS-1:0] expGroup(input logic [SLOTS*IW-1:0] w,
                                                input logic [SLOTS-1:0] pend);
    logic [SLOTS-1:0] m = '0;
    int s = -1;
    for (int i = 0; i < SLOTS; i++) if (pend[i] && s < 0) s = i;
    if (s >= 0) begin
      m[s] = 1'b1;
      while (s < SLOTS-1 && w[s*IW]) begin
        s++;
        m[s] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [SLOTS*IW-1:0] expWords(input logic [SLOTS*IW-1:0] w,
                                                   input logic [SLOTS-1:0] m);
    logic [SLOTS*IW-1:0] r = '0;
    for (int i = 0; i < SLOTS; i++) if (m[i]) r[i*IW +: IW] = w[i*IW +: IW];
    return r;
  endfunction

  function automatic logic [SLOTS*IW-1:0] makePkt(input int linkMode);
    logic [SLOTS*IW-1:0] r;
    for (int i = 0; i < SLOTS; i++) begin
      logic lk;
      case (linkMode)
        0: lk = 1'b0;
        1: lk = 1'b1;
        2: lk = 1'($urandom_range(0, 3) != 0);
        default: lk = 1'($urandom_range(0, 1));
      endcase
      r[i*IW +: IW] = {$urandom() >> 1, lk};
    end
    return r;
  endfunction

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=all packets issued");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [SLOTS*IW-1:0] mWords = '0;
    logic [SLOTS-1:0]    mPend  = '0;
    logic [SLOTS-1:0]    grp;
    logic [SLOTS-1:0]    prevMask = '0;
    logic [SLOTS*IW-1:0] prevWords = '0;
    bit prevStall = 1'b0;
    bit prevBoth  = 1'b0;
    bit doLoad, doAdv, expFr;
    int idx = 0;
    int cyc = 0;
    int stallPhase = 0;

    void'($urandom(32'd4242));
    // Directed packets first (R10, R6), then random ones
    pkts[0] = makePkt(1);
    pkts[1] = makePkt(0);
    pkts[2] = makePkt(1);
    pkts[3] = makePkt(3);
    pkts[3][7*IW] = 1'b1;   // R6: slot 7 link set, next packet independent
    for (int i = 4; i < NPKT; i++) pkts[i] = makePkt(2 + (i % 2));

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(issueValid == 1'b0, "R1 issueValid after reset", issueValid, 0);
    check(fetchReady == 1'b1, "R1 fetchReady after reset", fetchReady, 1);
    rstN = 1'b1;

    while (idx < NPKT || mPend != '0) begin
      @(negedge clk);
      cyc++;
      // Drive inputs for the coming edge
      fetchValid = (idx < NPKT) && ($urandom_range(0, 9) != 0);
      fetchWords = (idx < NPKT) ? pkts[idx] : '0;
      if (cyc < 40) issueReady = 1'b1;
      else if (stallPhase > 0) begin issueReady = 1'b0; stallPhase--; end
      else begin
        issueReady = ($urandom_range(0, 3) != 0);
        if ($urandom_range(0, 30) == 0) stallPhase = 3;
      end
      #1;
      grp = expGroup(mWords, mPend);
      check(issueValid == (mPend != '0), "R2 issueValid", issueValid, (mPend != '0));
      if (mPend != '0) begin
        check(issueMask == grp, "R3 R5 R6 R10 issueMask", issueMask, grp);
        check(issueWords == expWords(mWords, grp), "R4 issueWords",
              issueWords, expWords(mWords, grp));
      end
      if (prevStall)
        check(issueValid && issueMask == prevMask && issueWords == prevWords,
              "R8 held group", issueMask, prevMask);
      if (prevBoth)
        check(issueValid && issueMask[0], "R9 refill without gap", issueMask, 1);
      expFr = (mPend == '0) || (issueReady && ((mPend & ~grp) == '0));
      check(fetchReady == expFr, "R7 fetchReady", fetchReady, expFr);

      doLoad = fetchValid && expFr;
      doAdv  = (mPend != '0) && issueReady;
      prevStall = (mPend != '0) && !issueReady;
      prevBoth  = doLoad && doAdv;
      prevMask  = issueMask;
      prevWords = issueWords;
      if (doAdv) mPend = mPend & ~grp;
      if (doLoad) begin
        mWords = pkts[idx];
        mPend  = '1;
        idx++;
      end
    end
    @(negedge clk);
    fetchValid = 1'b0;
    #1;
    check(issueValid == 1'b0 && fetchReady == 1'b1, "R7 idle after drain", issueValid, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule